// File: doc/BRIEF.md
# Packed Multi-Lane Activation Stream Engine

The engine approximates a nonlinear activation function over a stream of 512-bit words. Each word carries 32 signed 16-bit fixed-point samples with 10 fraction bits. A sample is handled by its own lane. The lane compares the sample against a symmetric threshold to pick one of three regions, then evaluates that region's cubic polynomial with a chain of multiply-add steps. The 32 results are packed back into an output word in the positions their samples came from.

Software sets the run length in samples, the threshold, a degree for each region and four coefficients for each region, then pulses `start`. The engine copies all of these into internal registers at the pulse. It accepts `ceil(N/32)` input words on a valid/ready stream and emits the same number of output words on a second valid/ready stream. In a steady flow it takes one word per cycle. A full output stream freezes the whole pipeline. After the last output word is accepted, `done` pulses for one cycle.

Top module: `act_stream_engine`

## Requirements
- R1: Lane i occupies bits [16*i+15 : 16*i] of a word, with lane 0 in the least significant bits. The result for the input sample in lane i appears in lane i of the matching output word. Output words leave in the order their input words were accepted.
- R2: Take x as the signed sample and T as the signed threshold `cfg_thr`. The region is left (index 0) when x < -T, right (index 2) when x > T, and centre (index 1) otherwise, so both x = -T and x = T fall in the centre.
- R3: Coefficient k (the coefficient of x^k) of region r is the signed 16-bit field `cfg_coef[(4*r+k)*16 +: 16]`. The 24-bit accumulator starts at c3. Then, for k = 2, 1, 0 in turn, acc = wrap24(floor((acc*x) / 2^10) + c_k). The output is acc saturated to the range [-32768, 32767].
- R4: The degree of region r is `cfg_deg[2*r +: 2]`. Any coefficient whose power is above that degree is treated as zero, whatever its programmed value.
- R5: A run of N samples uses ceil(N/32) words. In the final word, every lane whose sample index is N or more outputs zero.
- R6: The length, threshold, degrees and coefficients are captured on the `start` pulse. Changing them during a run has no effect on that run's outputs or word count.
- R7: The first output word is valid 14 cycles after the cycle in which its input word was accepted. With both streams always willing, one word is accepted per cycle, and `done` rises N_words + 14 cycles after the first accept.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds steady and `in_ready` is low. No word is lost or repeated under any pattern of backpressure.
- R9: `done` is high for exactly one cycle, the cycle after the last output word is accepted. A start with N = 0 raises `done` in the following cycle and emits no word.
- R10: After reset and between runs, `in_ready`, `out_valid` and `done` are low. A `start` pulse during a run is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures the configuration and begins a run when idle |
| cfg_len | input | 24 | Run length in samples |
| cfg_thr | input | 16 | Signed region threshold |
| cfg_deg | input | 6 | Polynomial degree per region, 2 bits each |
| cfg_coef | input | 192 | Twelve signed 16-bit coefficients |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Engine accepts an input word |
| in_data | input | 512 | Packed input samples |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer accepts the output word |
| out_data | output | 512 | Packed results |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the engine with its defaults: 32 lanes of 16 bits, a 14-stage pipeline and a 24-bit length. At these values a run of 37 or 31 samples exercises tail masking on a partial word, and a 10-word full-rate run makes the exact 14-cycle latency and the one-word-per-cycle rate visible at the ports. The 16-bit width lets random coefficients drive the accumulator into saturation. Random ready gaps longer than the pipeline depth test the global stall, and random configuration changes and stray start pulses during a run test the captured settings.

// File: rtl/act_pkg.sv
package act_pkg;
    localparam int SAMPLE_W = 16;  // sample and coefficient width
    localparam int FRAC_W   = 10;  // fraction bits of the fixed-point format
    localparam int ACC_W    = 24;  // Horner accumulator width
    localparam int NREG     = 3;   // number of input regions
    localparam int NCOEF    = 4;   // cubic: c0..c3
    localparam int DEG_W    = 2;   // bits per region degree

    typedef enum logic [1:0] {
        REG_LEFT  = 2'd0,
        REG_MID   = 2'd1,
        REG_RIGHT = 2'd2
    } region_e;
endpackage

// File: rtl/act_lane.sv
module act_lane
    import act_pkg::*;
#(
    parameter int SW = SAMPLE_W,
    parameter int FW = FRAC_W,
    parameter int AW = ACC_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        en,
    input  logic [SW-1:0]               x_i,
    input  logic [SW-1:0]               thr_i,
    input  logic [NREG*DEG_W-1:0]       deg_i,
    input  logic [NREG*NCOEF*SW-1:0]    coef_i,
    output logic [SW-1:0]               y_o
);
    localparam int PW = AW + SW;
    localparam logic signed [AW-1:0] HI = AW'((1 << (SW-1)) - 1);
    localparam logic signed [AW-1:0] LO = -HI - AW'(1);

    typedef struct packed {
        logic signed [SW-1:0] x1;
        logic signed [SW-1:0] c13;
        logic signed [SW-1:0] c12;
        logic signed [SW-1:0] c11;
        logic signed [SW-1:0] c10;
        logic signed [SW-1:0] x2;
        logic signed [AW-1:0] acc2;
        logic signed [SW-1:0] c21;
        logic signed [SW-1:0] c20;
        logic signed [SW-1:0] x3;
        logic signed [AW-1:0] acc3;
        logic signed [SW-1:0] c30;
        logic signed [SW-1:0] y4;
    } lane_t;

    lane_t d, q;

    // one Horner step: floor(acc*x / 2^FW) + c, wrapped to AW bits (R3)
    function automatic logic signed [AW-1:0] mac(input logic signed [AW-1:0] a,
                                                 input logic signed [SW-1:0] xv,
                                                 input logic signed [SW-1:0] c);
        logic signed [PW-1:0] p;
        logic signed [PW-1:0] s;
        p = PW'(a) * PW'(xv);
        s = p >>> FW;
        return s[AW-1:0] + AW'(c);
    endfunction

    always_comb begin
        logic signed [SW:0]   xw;
        logic signed [SW:0]   tw;
        region_e              rsel;
        int                   r;
        int                   dg;
        logic signed [SW-1:0] c [NCOEF];
        logic signed [AW-1:0] f;
        d = q;
        // stage 1: region choice (R2) and degree mask (R4)
        xw = (SW+1)'($signed(x_i));
        tw = (SW+1)'($signed(thr_i));
        if (xw < -tw)     rsel = REG_LEFT;
        else if (xw > tw) rsel = REG_RIGHT;
        else              rsel = REG_MID;
        r  = int'(rsel);
        dg = int'(deg_i[r*DEG_W +: DEG_W]);
        for (int k = 0; k < NCOEF; k++)
            c[k] = (k <= dg) ? $signed(coef_i[(r*NCOEF+k)*SW +: SW]) : '0;
        // stages 2..4: Horner chain, then saturation
        f = mac(q.acc3, q.x3, q.c30);
        if (en) begin
            d.x1   = $signed(x_i);
            d.c13  = c[3];
            d.c12  = c[2];
            d.c11  = c[1];
            d.c10  = c[0];
            d.x2   = q.x1;
            d.acc2 = mac(AW'(q.c13), q.x1, q.c12);
            d.c21  = q.c11;
            d.c20  = q.c10;
            d.x3   = q.x2;
            d.acc3 = mac(q.acc2, q.x2, q.c21);
            d.c30  = q.c20;
            if (f > HI)      d.y4 = HI[SW-1:0];
            else if (f < LO) d.y4 = LO[SW-1:0];
            else             d.y4 = f[SW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign y_o = q.y4;
endmodule

// File: rtl/act_delay.sv
module act_delay #(
    parameter int W     = 8,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign q_o = d_i;
        end else begin : g_reg
            logic [W-1:0] pipe_d [DEPTH];
            logic [W-1:0] pipe_q [DEPTH];

            always_comb begin
                pipe_d = pipe_q;
                if (en) begin
                    pipe_d[0] = d_i;
                    for (int s = 1; s < DEPTH; s++) pipe_d[s] = pipe_q[s-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int s = 0; s < DEPTH; s++) pipe_q[s] <= '0;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign q_o = pipe_q[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/act_stream_engine.sv
module act_stream_engine
    import act_pkg::*;
#(
    parameter int LANES = 32,
    parameter int SW    = SAMPLE_W,
    parameter int LAT   = 14,
    parameter int LENW  = 24
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [LENW-1:0]             cfg_len,
    input  logic [SW-1:0]               cfg_thr,
    input  logic [NREG*DEG_W-1:0]       cfg_deg,
    input  logic [NREG*NCOEF*SW-1:0]    cfg_coef,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [LANES*SW-1:0]         in_data,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [LANES*SW-1:0]         out_data,
    output logic                        done
);
    localparam int WW          = LANES * SW;
    localparam int LG          = $clog2(LANES);
    localparam int CW          = LENW + 1 - LG;
    localparam int LANE_STAGES = 4;
    localparam int DLY         = LAT - LANE_STAGES;

    typedef struct packed {
        logic                     busy;
        logic                     done;
        logic [LENW-1:0]          len;
        logic [SW-1:0]            thr;
        logic [NREG*DEG_W-1:0]    deg;
        logic [NREG*NCOEF*SW-1:0] coef;
        logic [CW-1:0]            total;
        logic [CW-1:0]            in_cnt;
        logic [CW-1:0]            out_cnt;
        logic [LAT-1:0]           vld;
    } ctl_t;

    ctl_t d, q;

    logic          adv, in_fire, out_fire, last_word;
    logic [LENW:0] len_up;
    logic [CW-1:0] words_req;
    logic [WW-1:0] lane_y, dly_y;

    // word count rounds the sample count up (R5)
    assign len_up    = {1'b0, cfg_len} + (LENW+1)'(LANES - 1);
    assign words_req = CW'(len_up >> LG);

    // a full output register freezes every stage (R8)
    assign adv       = !(q.vld[LAT-1] && !out_ready);
    assign in_ready  = q.busy && (q.in_cnt < q.total) && adv;
    assign in_fire   = in_valid && in_ready;
    assign out_valid = q.vld[LAT-1];
    assign out_fire  = out_valid && out_ready;
    assign last_word = (q.out_cnt == q.total - 1'b1);
    assign done      = q.done;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (adv) d.vld = {q.vld[LAT-2:0], in_fire};
        if (in_fire) d.in_cnt = q.in_cnt + 1'b1;
        if (out_fire) begin
            if (last_word) begin          // R9
                d.busy    = 1'b0;
                d.done    = 1'b1;
                d.in_cnt  = '0;
                d.out_cnt = '0;
            end else begin
                d.out_cnt = q.out_cnt + 1'b1;
            end
        end
        if (start && !q.busy) begin       // R6, R10
            d.len     = cfg_len;
            d.thr     = cfg_thr;
            d.deg     = cfg_deg;
            d.coef    = cfg_coef;
            d.total   = words_req;
            d.in_cnt  = '0;
            d.out_cnt = '0;
            d.busy    = (words_req != '0);
            d.done    = (words_req == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // one lane per packed sample position (R1)
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        act_lane #(.SW(SW), .FW(FRAC_W), .AW(ACC_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (adv),
            .x_i   (in_data[i*SW +: SW]),
            .thr_i (q.thr),
            .deg_i (q.deg),
            .coef_i(q.coef),
            .y_o   (lane_y[i*SW +: SW])
        );
    end

    act_delay #(.W(WW), .DEPTH(DLY)) u_pad (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (adv),
        .d_i  (lane_y),
        .q_o  (dly_y)
    );

    // zero the lanes past the run length in the final word (R5)
    always_comb begin
        out_data = dly_y;
        if (last_word && q.len[LG-1:0] != '0) begin
            for (int i = 0; i < LANES; i++)
                if (i >= int'(q.len[LG-1:0])) out_data[i*SW +: SW] = '0;
        end
    end
endmodule

// File: rtl/act_stream_chk.sv
module act_stream_chk #(
    parameter int WW = 512
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [WW-1:0] out_data,
    input logic          done
);
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8

    AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid && !in_ready); // R10
endmodule

bind act_stream_engine act_stream_chk #(.WW(LANES*SW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .done     (done)
);

// File: tb/tb_act_stream_engine.sv
module tb_act_stream_engine;
    localparam int LANES = 32;
    localparam int SW    = 16;
    localparam int LAT   = 14;
    localparam int WW    = LANES * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [23:0]   cfg_len = '0;
    logic [15:0]   cfg_thr = '0;
    logic [5:0]    cfg_deg = '0;
    logic [191:0]  cfg_coef = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [WW-1:0] in_data = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [WW-1:0] out_data;
    logic          done;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    act_stream_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_len(cfg_len),
        .cfg_thr(cfg_thr), .cfg_deg(cfg_deg), .cfg_coef(cfg_coef),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done)
    );

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic check(input bit ok, input string tag,
                         input logic [WW-1:0] act, input logic [WW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint wrap24(input longint v);
        longint w;
        w = v & 64'hFFFFFF;
        if (w >= 64'sh800000) w = w - 64'sh1000000;
        return w;
    endfunction

    // requirement model of one lane (R2, R3, R4)
    function automatic logic [15:0] ref_lane(input logic [15:0] xs, input logic [15:0] thr,
                                             input logic [5:0] deg, input logic [191:0] coef);
        int     x, t, r, dg;
        longint acc;
        longint c [4];
        x = $signed(xs);
        t = $signed(thr);
        r = (x < -t) ? 0 : ((x > t) ? 2 : 1);
        dg = int'(deg[r*2 +: 2]);
        for (int k = 0; k < 4; k++)
            c[k] = (k <= dg) ? longint'($signed(coef[(r*4+k)*16 +: 16])) : 0;
        acc = c[3];
        for (int k = 2; k >= 0; k--) acc = wrap24(((acc * x) >>> 10) + c[k]);
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return acc[15:0];
    endfunction

    task automatic run_stream(input int n, input int mode, input int pv, input int pr,
                              input bit churn, input string tag);
        logic [15:0]   thr;
        logic [5:0]    deg;
        logic [191:0]  coef;
        logic [WW-1:0] word;
        logic [WW-1:0] expw;
        logic [WW-1:0] expq [$];
        int words, sent, got, cyc, first_in, first_out;
        bit pend, exp_done;
        words = (n + 31) / 32;
        thr = 16'($urandom_range(0, 4000));
        deg = 6'($urandom);
        for (int k = 0; k < 6; k++) coef[k*32 +: 32] = $urandom;
        if (mode == 1) begin
            deg  = '0;
            coef = '0;
            coef[0*64 +: 16] = 16'd100;
            coef[1*64 +: 16] = 16'd200;
            coef[2*64 +: 16] = 16'd300;
        end
        if (mode == 2) deg = {2'd1, 2'd1, 2'd1};
        @(negedge clk);
        cfg_len = 24'(n); cfg_thr = thr; cfg_deg = deg; cfg_coef = coef;
        start = 1'b1;
        sent = 0; got = 0; cyc = 0; first_in = -1; first_out = -1;
        pend = 1'b0; exp_done = (words == 0); word = '0;
        while (1) begin
            @(negedge clk);
            start = 1'b0;
            if (exp_done) begin
                check(done == 1'b1, {tag, " R9 done after last word"}, WW'(done), WW'(1));
                break;
            end
            if (done) begin
                check(1'b0, {tag, " R9 early done"}, WW'(got), WW'(words));
                break;
            end
            if (cyc > 20000) begin
                check(1'b0, {tag, " run timeout"}, WW'(got), WW'(words));
                break;
            end
            if (churn) begin    // R6, R10: settings and stray starts must not matter
                cfg_len = 24'($urandom); cfg_thr = 16'($urandom); cfg_deg = 6'($urandom);
                for (int k = 0; k < 6; k++) cfg_coef[k*32 +: 32] = $urandom;
                start = ($urandom_range(0, 7) == 0);
            end
            if (!pend && sent < words && $urandom_range(0, 99) < pv) begin
                for (int i = 0; i < LANES; i++) begin
                    int v;
                    case ((sent*32 + i) % 7)
                        0: v = -int'(thr) - 1;
                        1: v = -int'(thr);
                        2: v = 0;
                        3: v = int'(thr);
                        4: v = int'(thr) + 1;
                        5: v = 32767;
                        default: v = -32768;
                    endcase
                    word[i*16 +: 16] = (mode == 1) ? 16'(v) : 16'($urandom);
                    expw[i*16 +: 16] = (sent*32 + i < n) ?
                                       ref_lane(word[i*16 +: 16], thr, deg, coef) : 16'h0;
                end
                expq.push_back(expw);
                pend = 1'b1;
            end
            in_valid  = pend;
            in_data   = word;
            out_ready = ($urandom_range(0, 99) < pr);
            #1;
            if (out_valid && first_out < 0) first_out = cyc;
            if (out_valid && out_ready) begin
                expw = expq.pop_front();
                check(out_data == expw, {tag, " R1 output word"}, out_data, expw);
                got++;
                if (got == words) exp_done = 1'b1;
            end
            if (in_valid && in_ready) begin
                if (first_in < 0) first_in = cyc;
                pend = 1'b0;
                sent++;
            end
            cyc++;
        end
        in_valid = 1'b0;
        check(got == words, {tag, " R5 word count"}, WW'(got), WW'(words));
        if (mode == 3) begin
            check(first_out - first_in == LAT, {tag, " R7 latency"},
                  WW'(first_out - first_in), WW'(LAT));
            check(cyc - first_in == words + LAT, {tag, " R7 rate"},
                  WW'(cyc - first_in), WW'(words + LAT));
        end
        @(negedge clk);
        check(done == 1'b0, {tag, " R9 single pulse"}, WW'(done), WW'(0));
        in_valid = 1'b1;
        #1;
        check(!in_ready && !out_valid, {tag, " R10 idle after run"},
              WW'({in_ready, out_valid}), WW'(0));
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        in_valid = 1'b1;
        #1;
        check(!out_valid && !done, "R10 reset outputs", WW'({out_valid, done}), WW'(0));
        check(!in_ready, "R10 idle blocks input", WW'(in_ready), WW'(0));
        in_valid = 1'b0;

        run_stream(0,   0, 100, 100, 1'b0, "R9 empty run");
        run_stream(320, 3, 100, 100, 1'b0, "R7 full rate");
        run_stream(96,  1, 100, 100, 1'b0, "R2 boundaries");
        run_stream(64,  2, 80,  70,  1'b0, "R4 degree one");
        run_stream(37,  0, 100, 100, 1'b0, "R5 tail 37");
        run_stream(31,  0, 90,  90,  1'b0, "R5 tail 31");
        for (int it = 0; it < 8; it++)
            run_stream($urandom_range(1, 400), 0, 60, 40, 1'b1, "R3 R6 R8 random");

        summary();
        $finish;
    end
endmodule